// File: doc/BRIEF.md
# Two-Tier Interrupt Priority Merger

This block merges external interrupt requests with fifteen internal interrupt sources into a single prioritized request level for a processor core. External requests arrive either as a three-bit active-low encoded level (normal mode) or as three separate active-low request pins (dedicated mode). All internal sources share level 4. Among themselves they are ranked by a fixed chain, with the lower source index winning.

The block keeps one pending bit per internal source. An event pulse sets the bit. Software cannot clear it. The bit clears when the core acknowledges level 4 and the block hands back a vector for that source. The vector is a programmable 3-bit upper field followed by the 5-bit chain index of the source. A per-source enable mask keeps a source out of arbitration while its pending bit is held. External requests are never cleared by the block. The logic outside the block must remove them. `rst_n` is asserted asynchronously. Its release is expected to be synchronous to `clk`.

Top module: `irq_merge`

## Requirements
- R1: `ipl_n` is the bitwise inverse of the winning level (7 highest, 1 lowest), and 3'b111 means no request. The winner is the higher of the external level and level 4 when any unmasked internal source is pending.
- R2: In normal mode (`mode_ded`=0), `ext_lvl_n` value v requests level ~v. The values 3'b011 (level 4) and 3'b111 request nothing, and `ext_pins_n` is ignored.
- R3: In dedicated mode (`mode_ded`=1), the active-low pins request the following levels: `ext_pins_n[2]` requests level 7, `ext_pins_n[1]` requests level 6 and `ext_pins_n[0]` requests level 1. The highest asserted pin wins, and `ext_lvl_n` is ignored.
- R4: A high `src_evt[i]` sets pending bit i at the next clock edge. The chain positions are: 0 general input 3, 1 general input 2, 2 serial channel 1, 3 DMA bus error, 4 general DMA, 5 serial channel 2, 6 timer 1, 7 serial channel 3, 8 general input 1, 9 timer 2, 10 serial peripheral port, 11 timer 3, 12 management channel 1, 13 management channel 2, 14 general input 0.
- R5: Among pending, unmasked sources, the lowest index is the one selected.
- R6: When `iack_valid`=1, `iack_lvl`=4 and some unmasked source is pending, `vec_valid`=1 and `vec_out`={`vec_base`, 5-bit index of the selected source}. Otherwise `vec_valid`=0 and `vec_out`=0.
- R7: Such an acknowledge clears the selected pending bit at that clock edge and leaves the other bits unchanged. The next-highest pending source is presented in the following cycle.
- R8: If a pending bit is set and cleared in the same cycle, it stays set.
- R9: A source whose `mask_en` bit is 0 takes no part in arbitration and keeps its pending bit. Setting the enable bit again makes the source eligible.
- R10: An acknowledge at any level other than 4 changes no pending bit and has no effect on external requests.
- R11: Reset clears all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ded | input | 1 | 0 = encoded external level, 1 = separate pins |
| ext_lvl_n | input | 3 | Active-low encoded external level (normal mode) |
| ext_pins_n | input | 3 | Active-low request pins for levels 7, 6, 1 (dedicated mode) |
| src_evt | input | 15 | Internal source event pulses, index = chain position |
| mask_en | input | 15 | Per-source arbitration enable |
| vec_base | input | 3 | Upper field of the returned vector |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_lvl | input | 3 | Level being acknowledged |
| ipl_n | output | 3 | Active-low winning level to the core |
| vec_valid | output | 1 | Vector is being supplied |
| vec_out | output | 8 | Vector: base field and source index |

## Verification
The assertions run on every cycle. They check that the external level-4 code never produces a request, that a pending internal source always pulls the level to 4 or higher, that at most one source is selected, that a set takes precedence over a same-cycle clear, that no pending bit disappears without an acknowledge, and that the vector carries the base field. The bench scenarios are needed to show the actual order of the fifteen-entry chain, the full decode tables for both external modes, the hand-over to the next-highest source after each acknowledge, and a masked source coming back once it is enabled again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC_DEF = 15;
  localparam int LVL_W     = 3;
  localparam int VEC_W_DEF = 8;
  localparam logic [LVL_W-1:0] INT_LVL  = 3'd4;
  localparam logic [LVL_W-1:0] LVL_NONE = 3'd0;
endpackage

// File: rtl/irq_ext_decode.sv
module irq_ext_decode
  import irq_pkg::*;
(
  input  logic             mode_ded,
  input  logic [LVL_W-1:0] ext_lvl_n,
  input  logic [2:0]       ext_pins_n,
  output logic [LVL_W-1:0] ext_lvl
);
  logic [LVL_W-1:0] enc_lvl;

  always_comb begin
    enc_lvl = ~ext_lvl_n;
    if (enc_lvl == INT_LVL) enc_lvl = LVL_NONE;
  end

  always_comb begin
    if (mode_ded) begin
      if (!ext_pins_n[2])      ext_lvl = 3'd7;
      else if (!ext_pins_n[1]) ext_lvl = 3'd6;
      else if (!ext_pins_n[0]) ext_lvl = 3'd1;
      else                     ext_lvl = LVL_NONE;
    end else begin
      ext_lvl = enc_lvl;
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;
  logic         upd_en;

  always_comb begin
    upd_en = (|set_i) | (|clr_i);
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_chain_pick.sv
module irq_chain_pick #(
  parameter int N     = 15,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [N-1:0]     oh,
  output logic [IDX_W-1:0] idx
);
  logic [N:0] above;

  assign above[0] = 1'b0;
  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      assign oh[g]      = req[g] & ~above[g];
      assign above[g+1] = above[g] | req[g];
    end
  endgenerate
  assign any = above[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_pkg::*;
#(
  parameter int N_SRC  = N_SRC_DEF,
  parameter int VEC_W  = VEC_W_DEF,
  localparam int IDX_W  = 5,
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ded,
  input  logic [2:0]        ext_lvl_n,
  input  logic [2:0]        ext_pins_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [N_SRC-1:0]  mask_en,
  input  logic [BASE_W-1:0] vec_base,
  input  logic              iack_valid,
  input  logic [2:0]        iack_lvl,
  output logic [2:0]        ipl_n,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  logic [LVL_W-1:0] ext_lvl;
  logic [LVL_W-1:0] win_lvl;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] act;
  logic [N_SRC-1:0] pick_oh;
  logic [N_SRC-1:0] clr_vec;
  logic [IDX_W-1:0] pick_idx;
  logic             any_act;
  logic             ack_hit;

  irq_ext_decode u_dec (
    .mode_ded   (mode_ded),
    .ext_lvl_n  (ext_lvl_n),
    .ext_pins_n (ext_pins_n),
    .ext_lvl    (ext_lvl)
  );

  irq_pend_bank #(.N(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_evt),
    .clr_i  (clr_vec),
    .pend_q (pend_q)
  );

  assign act = pend_q & mask_en;

  irq_chain_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .req (act),
    .any (any_act),
    .oh  (pick_oh),
    .idx (pick_idx)
  );

  always_comb begin
    if (any_act && (ext_lvl < INT_LVL)) win_lvl = INT_LVL;
    else                                win_lvl = ext_lvl;
    ipl_n = ~win_lvl;
  end

  always_comb begin
    ack_hit   = iack_valid && (iack_lvl == INT_LVL) && any_act;
    vec_valid = ack_hit;
    vec_out   = ack_hit ? {vec_base, pick_idx} : '0;
    clr_vec   = ack_hit ? pick_oh : '0;
  end
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int N_SRC  = 15,
  parameter int VEC_W  = 8,
  parameter int BASE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ded,
  input logic [2:0]        ext_lvl_n,
  input logic [N_SRC-1:0]  src_evt,
  input logic [BASE_W-1:0] vec_base,
  input logic [2:0]        ipl_n,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  pick_oh,
  input logic              any_act
);
  a_r1_int_floor: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> (ipl_n <= 3'b011));

  a_r2_no_ext_lvl4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ded && ext_lvl_n == 3'b011 && !any_act) |-> (ipl_n == 3'b111));

  a_r5_one_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  a_r6_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[VEC_W-1:VEC_W-BASE_W] == vec_base));

  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> ((pend_q & $past(pick_oh) & ~$past(src_evt)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  a_r9_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind irq_merge irq_merge_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_ded  (mode_ded),
  .ext_lvl_n (ext_lvl_n),
  .src_evt   (src_evt),
  .vec_base  (vec_base),
  .ipl_n     (ipl_n),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .pend_q    (pend_q),
  .pick_oh   (pick_oh),
  .any_act   (any_act)
);

// File: tb/irq_merge_bench.sv
module irq_merge_bench;
  localparam int N = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_ded;
  logic [2:0]    ext_lvl_n;
  logic [2:0]    ext_pins_n;
  logic [N-1:0]  src_evt;
  logic [N-1:0]  mask_en;
  logic [2:0]    vec_base;
  logic          iack_valid;
  logic [2:0]    iack_lvl;
  logic [2:0]    ipl_n;
  logic          vec_valid;
  logic [7:0]    vec_out;

  logic [N-1:0]  m_pend;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 0;

  always #10 clk = ~clk;

  irq_merge u_irq_merge (
    .clk(clk), .rst_n(rst_n), .mode_ded(mode_ded), .ext_lvl_n(ext_lvl_n),
    .ext_pins_n(ext_pins_n), .src_evt(src_evt), .mask_en(mask_en),
    .vec_base(vec_base), .iack_valid(iack_valid), .iack_lvl(iack_lvl),
    .ipl_n(ipl_n), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  function automatic logic [2:0] f_ext(logic md, logic [2:0] ln, logic [2:0] pn);
    logic [2:0] l;
    if (md) begin
      if (!pn[2]) return 3'd7;
      if (!pn[1]) return 3'd6;
      if (!pn[0]) return 3'd1;
      return 3'd0;
    end
    l = ~ln;
    return (l == 3'd4) ? 3'd0 : l;
  endfunction

  function automatic int f_top(logic [N-1:0] p, logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (p[i] && m[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Called just after a negedge with inputs already driven.
  task automatic run_cycle(string tag);
    int         top;
    logic [2:0] el, wl;
    logic       hit;
    #2;
    top = f_top(m_pend, mask_en);
    el  = f_ext(mode_ded, ext_lvl_n, ext_pins_n);
    wl  = (top >= 0 && el < 3'd4) ? 3'd4 : el;
    hit = iack_valid && iack_lvl == 3'd4 && top >= 0;
    check({tag, " ipl"}, {5'd0, ipl_n}, {5'd0, ~wl});
    check({tag, " vld"}, {7'd0, vec_valid}, {7'd0, hit});
    check({tag, " vec"}, vec_out, hit ? {vec_base, 5'(top)} : 8'd0);
    if (hit) m_pend[top] = 1'b0;
    m_pend = m_pend | src_evt;
    @(negedge clk);
  endtask

  task automatic idle_in();
    src_evt = '0; iack_valid = 0; iack_lvl = 3'd0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; mode_ded = 0; ext_lvl_n = 3'b111; ext_pins_n = 3'b111;
    mask_en = '1; vec_base = 3'b101; m_pend = '0;
    idle_in();
    @(negedge clk);
    run_cycle("R11 reset");
    rst_n = 1;
    run_cycle("R11 idle");

    // R2: level-4 code and 111 give no request; 001 gives level 6
    ext_lvl_n = 3'b011; run_cycle("R2 code4");
    ext_lvl_n = 3'b001; run_cycle("R2 lvl6");
    ext_lvl_n = 3'b110; ext_pins_n = 3'b000; run_cycle("R2 lvl1 pins ignored");
    // R3: dedicated pins, encoded input ignored
    mode_ded = 1; ext_lvl_n = 3'b000;
    ext_pins_n = 3'b110; run_cycle("R3 pin1");
    ext_pins_n = 3'b100; run_cycle("R3 pin6");
    ext_pins_n = 3'b010; run_cycle("R3 pin7");
    ext_pins_n = 3'b111; run_cycle("R3 none");
    mode_ded = 0; ext_lvl_n = 3'b111;

    // R4 / R5 / R6 / R7: two sources, served in chain order
    src_evt = (15'd1 << 9) | (15'd1 << 3); run_cycle("R4 set");
    idle_in(); run_cycle("R4 presented");
    iack_valid = 1; iack_lvl = 3'd4; run_cycle("R6 vec idx3");
    run_cycle("R7 next idx9");
    run_cycle("R7 empty");
    idle_in();

    // R8: set and clear same cycle
    src_evt = 15'd1 << 2; run_cycle("R8 prep");
    iack_valid = 1; iack_lvl = 3'd4; run_cycle("R8 collide");
    idle_in(); run_cycle("R8 still pending");
    iack_valid = 1; iack_lvl = 3'd4; run_cycle("R8 drain");
    idle_in();

    // R9: masked source keeps pending, returns on unmask
    mask_en = ~15'd1; src_evt = 15'd1 | (15'd1 << 5); run_cycle("R9 set");
    idle_in(); iack_valid = 1; iack_lvl = 3'd4; run_cycle("R9 masked skip");
    run_cycle("R9 none eligible");
    idle_in(); mask_en = '1; run_cycle("R9 unmasked");
    iack_valid = 1; iack_lvl = 3'd4; run_cycle("R9 serve idx0");
    idle_in();

    // R10: acknowledge at level 6 touches nothing
    src_evt = 15'd1 << 7; run_cycle("R10 prep");
    idle_in(); ext_lvl_n = 3'b001; iack_valid = 1; iack_lvl = 3'd6;
    run_cycle("R10 ack6");
    idle_in(); run_cycle("R10 ext held");
    ext_lvl_n = 3'b111; run_cycle("R10 int kept");

    // R11: reset mid-run clears pending
    src_evt = 15'h7fff; run_cycle("R11 prep");
    idle_in(); rst_n = 0; m_pend = '0; run_cycle("R11 cleared");
    rst_n = 1; run_cycle("R11 after");

    // R1 / R5 / R6 random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] ev;
      ev = '0;
      for (int b = 0; b < N; b++) ev[b] = ($urandom % 10) == 0;
      src_evt    = ev;
      mask_en    = (($urandom % 4) == 0) ? N'($urandom) : '1;
      mode_ded   = ($urandom % 3) == 0;
      ext_lvl_n  = (($urandom % 2) == 0) ? 3'b111 : 3'($urandom);
      ext_pins_n = (($urandom % 2) == 0) ? 3'b111 : 3'($urandom);
      vec_base   = 3'($urandom);
      iack_valid = ($urandom % 2) == 0;
      iack_lvl   = (($urandom % 3) == 0) ? 3'($urandom) : 3'd4;
      run_cycle("R1 R5 R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule